// File: doc/BRIEF.md
# Capacitance Sample Calibration Datapath

This block turns a raw signed 24-bit converter sample into the calibrated result that a measurement slot stores. It keeps one offset trim and one gain trim for each input channel. The trims are loaded through a small pointer-addressed write port. Each incoming sample carries the index of its slot's positive channel. That index picks the pair of trims applied to the sample. The corrected value is clamped to the signed 24-bit range and then split into two 16-bit result words.

The arithmetic runs in two registered stages. The first stage multiplies the sample by the gain trim. The second stage scales the product back down, adds the aligned offset trim, and saturates the sum. Along with the data, the block reports the coarse offset of the slot's offset-DAC code in femtofarads, so that a host can add it when it interprets a single-ended result. A clear input puts every trim back to its default.

Top module: `cap_cal_path`

## Requirements
- R1: After reset every gain trim is 0x4000 (unity) and every offset trim is 0x0000, so a sample leaves the block with its value unchanged.
- R2: The result is floor(raw × gain / 2^14) + offset × 2^8. Here raw is the signed 24-bit sample, gain is an unsigned Q2.14 trim and offset is a signed Q5.11 trim in pF. The result scale is 2^19 codes per pF.
- R3: A sum above 0x7FFFFF is clamped to 0x7FFFFF.
- R4: A sum below −2^23 is clamped to 0x800000.
- R5: `out_hi` carries result bits [23:8]. `out_lo` carries result bits [7:0] in its upper byte, and its low byte is always zero.
- R6: Offset trims for channels 0..3 are written at addresses 0x0D..0x10 and gain trims at 0x11..0x14. A sample uses only the trims of the channel given on `in_chan`.
- R7: A write to any address outside 0x0D..0x14 changes no trim.
- R8: A pulse on `trim_clr` returns all eight trims to their defaults on the next edge.
- R9: `out_valid` rises exactly two clock cycles after each `in_valid` strobe, with the matching data. It stays low in the cycles that follow an idle input cycle. One sample may be accepted in every cycle.
- R10: `out_cap_ff` reports code × 3125 fF for the 5-bit offset-DAC code of the sample, which covers 0 to 96875 fF. It is aligned with the result words.
- R11: A trim write in the same cycle as a sample takes effect only for later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_clr | input | 1 | Restores all trims to their defaults |
| wr_en | input | 1 | Trim write strobe |
| wr_addr | input | 8 | Trim write pointer |
| wr_data | input | 16 | Trim write value |
| in_valid | input | 1 | Sample strobe |
| in_raw | input | 24 | Raw two's-complement sample |
| in_chan | input | 2 | Positive channel of the sample's slot |
| in_dac | input | 5 | Offset-DAC code of the slot |
| out_valid | output | 1 | Result words are valid |
| out_hi | output | 16 | Result bits [23:8] |
| out_lo | output | 16 | Result bits [7:0], then a zero byte |
| out_cap_ff | output | 17 | Coarse offset in fF |

## Verification
The bench drives a sample on a falling edge. The sample passes through the multiply register and the add/saturate register, so its result words, its offset report and `out_valid` are sampled on the second falling edge after the drive. The bench also checks that `out_valid` is still low on the first falling edge. Trim writes land on the rising edge that follows the drive. A sample issued together with a write is therefore expected to use the old trims. In the streaming test each falling edge compares the outputs against the stimulus from two cycles earlier, so back-to-back and gapped strobes are both held to the fixed latency.

// File: rtl/cap_cal_pkg.sv
package cap_cal_pkg;
   // What a write pointer selects for one channel
   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_OFFSET = 2'd1,
      TGT_GAIN   = 2'd2
   } trim_tgt_e;
endpackage

// File: rtl/cal_trim_bank.sv
module cal_trim_bank
   import cap_cal_pkg::*;
#(
   parameter int CH        = 4,
   parameter int TW        = 16,
   parameter int ADDR_W    = 8,
   parameter int OFF_BASE  = 13,
   parameter int GAIN_BASE = 17,
   parameter int GAIN_RST  = 16384,
   localparam int CHW      = $clog2(CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [TW-1:0]    wr_data_i,
   input  logic [CHW-1:0]   sel_i,
   output logic [TW-1:0]    off_o,
   output logic [TW-1:0]    gain_o,
   output logic [CH*TW-1:0] off_flat_o,
   output logic [CH*TW-1:0] gain_flat_o
);
   for (genvar g = 0; g < CH; g++) begin : g_ch
      trim_tgt_e    tgt;
      logic [TW-1:0] off_q, gain_q;

      always_comb begin
         tgt = TGT_NONE;
         if (wr_en_i && wr_addr_i == ADDR_W'(OFF_BASE + g))
            tgt = TGT_OFFSET;
         else if (wr_en_i && wr_addr_i == ADDR_W'(GAIN_BASE + g))
            tgt = TGT_GAIN;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            off_q  <= '0;
            gain_q <= TW'(GAIN_RST);
         end else if (clr_i) begin
            off_q  <= '0;
            gain_q <= TW'(GAIN_RST);
         end else begin
            if (tgt == TGT_OFFSET) off_q  <= wr_data_i;
            if (tgt == TGT_GAIN)   gain_q <= wr_data_i;
         end
      end

      assign off_flat_o[g*TW +: TW]  = off_q;
      assign gain_flat_o[g*TW +: TW] = gain_q;
   end

   assign off_o  = off_flat_o[int'(sel_i)*TW +: TW];
   assign gain_o = gain_flat_o[int'(sel_i)*TW +: TW];
endmodule

// File: rtl/cal_mult_stage.sv
module cal_mult_stage #(
   parameter int RAW_W = 24,
   parameter int TW    = 16,
   parameter int DAC_W = 5,
   localparam int PW   = RAW_W + TW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic [RAW_W-1:0]     raw_i,
   input  logic [TW-1:0]        gain_i,
   input  logic [TW-1:0]        off_i,
   input  logic [DAC_W-1:0]     dac_i,
   output logic                 v_o,
   output logic signed [PW-1:0] prod_o,
   output logic [TW-1:0]        off_o,
   output logic [DAC_W-1:0]     dac_o
);
   logic signed [PW-1:0] raw_x, gain_x, mult_c;

   assign raw_x  = $signed({{(PW-RAW_W){raw_i[RAW_W-1]}}, raw_i});
   assign gain_x = $signed({{(PW-TW){1'b0}}, gain_i});
   assign mult_c = raw_x * gain_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o    <= 1'b0;
         prod_o <= '0;
         off_o  <= '0;
         dac_o  <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            prod_o <= mult_c;
            off_o  <= off_i;
            dac_o  <= dac_i;
         end
      end
   end
endmodule

// File: rtl/cal_sum_stage.sv
module cal_sum_stage #(
   parameter int RAW_W     = 24,
   parameter int TW        = 16,
   parameter int WORD_W    = 16,
   parameter int DAC_W     = 5,
   parameter int GAIN_FRAC = 14,
   parameter int OFF_SHIFT = 8,
   parameter int STEP_FF   = 3125,
   parameter int CAP_W     = 17,
   localparam int PW       = RAW_W + TW + 1,
   localparam int SW       = PW + 1,
   localparam int LOW_W    = RAW_W - WORD_W,
   localparam int ZW       = WORD_W - LOW_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 v_i,
   input  logic signed [PW-1:0] prod_i,
   input  logic [TW-1:0]        off_i,
   input  logic [DAC_W-1:0]     dac_i,
   output logic                 v_o,
   output logic [WORD_W-1:0]    hi_o,
   output logic [WORD_W-1:0]    lo_o,
   output logic [CAP_W-1:0]     cap_o
);
   logic signed [SW-1:0] prod_x, scaled, off_x, sum_c;
   logic [RAW_W-1:0]     res_c;
   logic                 ovf;
   logic [CAP_W-1:0]     cap_c;

   assign prod_x = $signed({prod_i[PW-1], prod_i});
   assign scaled = prod_x >>> GAIN_FRAC;
   assign off_x  = $signed({{(SW-TW){off_i[TW-1]}}, off_i}) <<< OFF_SHIFT;
   assign sum_c  = scaled + off_x;

   // out of range when the bits above the result sign disagree with it
   assign ovf = (sum_c[SW-1:RAW_W-1] != {(SW-RAW_W+1){sum_c[SW-1]}});

   always_comb begin
      if (ovf) res_c = {sum_c[SW-1], {(RAW_W-1){~sum_c[SW-1]}}};
      else     res_c = sum_c[RAW_W-1:0];
   end

   assign cap_c = CAP_W'(dac_i) * CAP_W'(STEP_FF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_o   <= 1'b0;
         hi_o  <= '0;
         lo_o  <= '0;
         cap_o <= '0;
      end else begin
         v_o <= v_i;
         if (v_i) begin
            hi_o  <= res_c[RAW_W-1 -: WORD_W];
            lo_o  <= {res_c[LOW_W-1:0], {ZW{1'b0}}};
            cap_o <= cap_c;
         end
      end
   end
endmodule

// File: rtl/cap_cal_path.sv
module cap_cal_path #(
   parameter int CHANNELS    = 4,
   parameter int RAW_W       = 24,
   parameter int TRIM_W      = 16,
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int DAC_W       = 5,
   parameter int GAIN_FRAC   = 14,
   parameter int OFF_FRAC    = 11,
   parameter int RES_FRAC    = 19,
   parameter int OFF_BASE    = 13,
   parameter int GAIN_BASE   = 17,
   parameter int GAIN_RESET  = 16384,
   parameter int DAC_STEP_FF = 3125,
   localparam int CHAN_W     = $clog2(CHANNELS),
   localparam int CAP_W      = $clog2(((1 << DAC_W) - 1) * DAC_STEP_FF + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trim_clr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [TRIM_W-1:0] wr_data,
   input  logic              in_valid,
   input  logic [RAW_W-1:0]  in_raw,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic [DAC_W-1:0]  in_dac,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_hi,
   output logic [WORD_W-1:0] out_lo,
   output logic [CAP_W-1:0]  out_cap_ff
);
   localparam int OFF_SHIFT = RES_FRAC - OFF_FRAC;
   localparam int PW        = RAW_W + TRIM_W + 1;

   if (CHANNELS < 2)                      begin : g_bad_ch  $error("CHANNELS must be at least 2"); end
   if (RAW_W <= WORD_W || RAW_W > 2*WORD_W) begin : g_bad_w $error("RAW_W must fit two words"); end
   if (OFF_SHIFT < 0)                     begin : g_bad_sh  $error("offset fraction exceeds result fraction"); end
   if (GAIN_BASE < OFF_BASE + CHANNELS)   begin : g_bad_map $error("trim address ranges overlap"); end

   logic [TRIM_W-1:0]          sel_off, sel_gain, s1_off;
   logic [CHANNELS*TRIM_W-1:0] off_flat, gain_flat;
   logic                       s1_v;
   logic signed [PW-1:0]       s1_prod;
   logic [DAC_W-1:0]           s1_dac;

   cal_trim_bank #(
      .CH(CHANNELS), .TW(TRIM_W), .ADDR_W(ADDR_W),
      .OFF_BASE(OFF_BASE), .GAIN_BASE(GAIN_BASE), .GAIN_RST(GAIN_RESET)
   ) i_trims (
      .clk(clk), .rst_n(rst_n), .clr_i(trim_clr),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .sel_i(in_chan), .off_o(sel_off), .gain_o(sel_gain),
      .off_flat_o(off_flat), .gain_flat_o(gain_flat)
   );

   cal_mult_stage #(.RAW_W(RAW_W), .TW(TRIM_W), .DAC_W(DAC_W)) i_mult (
      .clk(clk), .rst_n(rst_n), .v_i(in_valid), .raw_i(in_raw),
      .gain_i(sel_gain), .off_i(sel_off), .dac_i(in_dac),
      .v_o(s1_v), .prod_o(s1_prod), .off_o(s1_off), .dac_o(s1_dac)
   );

   cal_sum_stage #(
      .RAW_W(RAW_W), .TW(TRIM_W), .WORD_W(WORD_W), .DAC_W(DAC_W),
      .GAIN_FRAC(GAIN_FRAC), .OFF_SHIFT(OFF_SHIFT),
      .STEP_FF(DAC_STEP_FF), .CAP_W(CAP_W)
   ) i_sum (
      .clk(clk), .rst_n(rst_n), .v_i(s1_v), .prod_i(s1_prod),
      .off_i(s1_off), .dac_i(s1_dac),
      .v_o(out_valid), .hi_o(out_hi), .lo_o(out_lo), .cap_o(out_cap_ff)
   );
endmodule

// File: rtl/cap_cal_chk.sv
module cap_cal_chk #(
   parameter int CH      = 4,
   parameter int TW      = 16,
   parameter int WORD_W  = 16,
   parameter int ZW      = 8,
   parameter int CAP_W   = 17,
   parameter int STEP_FF = 3125,
   parameter int GAIN_RST = 16384
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trim_clr,
   input logic              wr_en,
   input logic              in_valid,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_lo,
   input logic [CAP_W-1:0]  out_cap_ff,
   input logic [CH*TW-1:0]  off_flat,
   input logic [CH*TW-1:0]  gain_flat
);
   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_clr |=> (gain_flat == {CH{TW'(GAIN_RST)}}) && (off_flat == '0));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !trim_clr) |=> ($stable(gain_flat) && $stable(off_flat)));
   // R5
   low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_lo[ZW-1:0] == '0));
   // R10
   cap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_cap_ff % CAP_W'(STEP_FF)) == '0));
endmodule

bind cap_cal_path cap_cal_chk #(
   .CH(CHANNELS), .TW(TRIM_W), .WORD_W(WORD_W), .ZW(2*WORD_W-RAW_W),
   .CAP_W(CAP_W), .STEP_FF(DAC_STEP_FF), .GAIN_RST(GAIN_RESET)
) i_chk (
   .clk(clk), .rst_n(rst_n), .trim_clr(trim_clr), .wr_en(wr_en),
   .in_valid(in_valid), .out_valid(out_valid), .out_lo(out_lo),
   .out_cap_ff(out_cap_ff), .off_flat(off_flat), .gain_flat(gain_flat)
);

// File: tb/test_cap_cal_path.sv
module test_cap_cal_path;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trim_clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic [23:0] in_raw = '0;
   logic [1:0]  in_chan = '0;
   logic [4:0]  in_dac = '0;
   logic        out_valid;
   logic [15:0] out_hi, out_lo;
   logic [16:0] out_cap_ff;

   int n_tot = 0;
   int n_bad = 0;
   logic [15:0] m_off[4];
   logic [15:0] m_gain[4];

   always #10 clk = ~clk;

   cap_cal_path i_cap_cal_path (.*);

   function automatic logic [23:0] model(logic [23:0] raw, logic [15:0] g, logic [15:0] o);
      longint r, s;
      r = longint'($signed(raw));
      s = (r * longint'(g)) >>> 14;
      s = s + longint'($signed(o)) * 256;
      if (s > 64'sd8388607)  s = 64'sd8388607;
      if (s < -64'sd8388608) s = -64'sd8388608;
      return s[23:0];
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_tot++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a >= 8'h0D && a <= 8'h10) m_off[a - 8'h0D] = d;
      if (a >= 8'h11 && a <= 8'h14) m_gain[a - 8'h11] = d;
   endtask

   task automatic clear_trims();
      @(negedge clk);
      trim_clr = 1'b1;
      @(negedge clk);
      trim_clr = 1'b0;
      for (int k = 0; k < 4; k++) begin m_off[k] = 16'h0; m_gain[k] = 16'h4000; end
   endtask

   task automatic check_out(string req, logic [23:0] e, logic [4:0] dac);
      chk(req, "out_valid", 32'(out_valid), 32'd1);
      chk(req, "out_hi", 32'(out_hi), 32'(e[23:8]));
      chk(req, "out_lo", 32'(out_lo), 32'({e[7:0], 8'h00}));
      chk("R10", "out_cap_ff", 32'(out_cap_ff), 32'(dac) * 32'd3125);
   endtask

   task automatic send(string req, logic [23:0] raw, logic [1:0] ch, logic [4:0] dac);
      logic [23:0] e;
      e = model(raw, m_gain[ch], m_off[ch]);
      @(negedge clk);
      in_valid = 1'b1; in_raw = raw; in_chan = ch; in_dac = dac;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9", "out_valid early", 32'(out_valid), 32'd0);
      @(negedge clk);
      check_out(req, e, dac);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tot++; n_bad++;
      $display("FAIL watchdog expired got=running exp=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < 4; k++) begin m_off[k] = 16'h0; m_gain[k] = 16'h4000; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "out_valid after reset", 32'(out_valid), 32'd0);

      // R1: defaults pass samples through unchanged
      send("R1", 24'h123456, 2'd0, 5'd0);
      send("R1", 24'hFEDCBA, 2'd3, 5'd1);

      // R2, R6: half gain and +1 pF offset on channel 2 only
      wr(8'h13, 16'h2000);
      wr(8'h0F, 16'h0800);
      send("R2", 24'h100000, 2'd2, 5'd31);
      send("R2", 24'hFFFFFF, 2'd2, 5'd2);
      send("R6", 24'h100000, 2'd1, 5'd3);
      wr(8'h0D, 16'hF800);
      send("R6", 24'h000000, 2'd0, 5'd0);

      // R3, R4: saturation at both ends
      wr(8'h12, 16'hFFFF);
      send("R3", 24'h7FFFFF, 2'd1, 5'd4);
      send("R4", 24'h800000, 2'd1, 5'd5);
      wr(8'h10, 16'h7FFF);
      send("R3", 24'h7F0000, 2'd3, 5'd6);
      wr(8'h10, 16'h8000);
      send("R4", 24'h800100, 2'd3, 5'd7);

      // R7: writes outside the trim window change nothing
      wr(8'h0C, 16'h1234);
      wr(8'h15, 16'h5555);
      wr(8'hFF, 16'hAAAA);
      for (int k = 0; k < 4; k++) send("R7", 24'h0ABCDE, 2'(k), 5'(k));

      // R8: clear restores defaults on every channel
      clear_trims();
      for (int k = 0; k < 4; k++) send("R8", 24'h345678 + 24'(k), 2'(k), 5'd9);

      // R11: write and sample in the same cycle uses the old trim
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h11; wr_data = 16'h8000;
      in_valid = 1'b1; in_raw = 24'h001000; in_chan = 2'd0; in_dac = 5'd1;
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0; m_gain[0] = 16'h8000;
      @(negedge clk);
      check_out("R11", 24'h001000, 5'd1);
      send("R11", 24'h001000, 2'd0, 5'd1);

      // R2, R9: random trims, then a random stream with gaps
      for (int k = 0; k < 4; k++) begin
         wr(8'h0D + 8'(k), 16'($urandom));
         wr(8'h11 + 8'(k), 16'($urandom));
      end
      begin
         logic        sv[202];
         logic [23:0] se[202];
         logic [4:0]  sd[202];
         for (int i = 0; i < 202; i++) begin
            @(negedge clk);
            if (i >= 2) begin
               chk("R9", "stream valid", 32'(out_valid), 32'(sv[i-2]));
               if (sv[i-2]) begin
                  chk("R2", "stream hi", 32'(out_hi), 32'(se[i-2][23:8]));
                  chk("R5", "stream lo", 32'(out_lo), 32'({se[i-2][7:0], 8'h00}));
                  chk("R10", "stream cap", 32'(out_cap_ff), 32'(sd[i-2]) * 32'd3125);
               end
            end
            if (i < 200) begin
               logic [1:0] c;
               sv[i] = ($urandom % 4) != 0;
               c     = 2'($urandom);
               sd[i] = 5'($urandom);
               in_raw = 24'($urandom);
               in_chan = c; in_dac = sd[i]; in_valid = sv[i];
               se[i] = model(in_raw, m_gain[c], m_off[c]);
            end else begin
               in_valid = 1'b0;
            end
         end
      end
      finish_run();
   end
endmodule